// File: doc/BRIEF.md
# Level-Sequenced Two-Head Traffic Controller

This block drives the lamps of two signal heads, called head A and head B, at a crossing. Each head has a red, a yellow and a green lamp. The controller has no phase timers of its own. A single timing level, produced elsewhere, decides when the lamps change. While that level is low, one head is green and the other is red. Raising the level turns the green head yellow. Lowering it again turns the yellow head red and gives the green to the other head, so the right of way alternates.

The four phases repeat in a fixed ring: A green, then A yellow, then B green, then B yellow, then back to A green. The timing level is sampled on the rising clock edge. The lamp outputs are decoded from the state register without any further register stage, so a phase change shows on the lamps in the same clock period as the edge that caused it.

A build parameter chooses how the state is stored. One option keeps one flip-flop per phase. The other keeps a two-bit binary code and decodes it. The two options behave the same at the ports.

Top module: `tlc_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it is released, head A shows green and head B shows red.
- R2: In a green phase, a clock edge that samples `timing_in` = 0 leaves both heads unchanged.
- R3: From A green / B red, an edge that samples `timing_in` = 1 gives A yellow / B red after that edge.
- R4: In a yellow phase, an edge that samples `timing_in` = 1 leaves both heads unchanged.
- R5: From A yellow / B red, an edge that samples `timing_in` = 0 gives A red / B green after that edge.
- R6: From A red / B green, an edge that samples `timing_in` = 1 gives A red / B yellow after that edge.
- R7: From A red / B yellow, an edge that samples `timing_in` = 0 gives A green / B red after that edge.
- R8: Each lamp vector is one-hot in every cycle. Bit 0 is red, bit 1 is yellow and bit 2 is green.
- R9: At least one of the two heads shows red in every cycle, so both heads are never green or yellow at the same time.
- R10: `ENC_BINARY` = 0 selects one flip-flop per phase, and `ENC_BINARY` = 1 selects a two-bit code with a decoder. Both settings give the same lamp sequence for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| timing_in | input | 1 | External timing level that sequences the phases |
| lamp_a | output | 3 | Head A lamps, one-hot {green, yellow, red} |
| lamp_b | output | 3 | Head B lamps, one-hot {green, yellow, red} |

## Verification
The lamps are a pure decode of the state, so a wrong state shows on the ports in the same period as the edge that produced it. A missed or spurious advance shows as the wrong head being lit. A corrupted one-hot register shows as a non-one-hot lamp vector, or as two heads lit at once. The bench runs both encodings side by side on the same stimulus and compares them against a phase model after every edge. A single-cycle timing pulse, a long hold and a reset in the middle of a cycle each show a divergence by the next sample.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int unsigned NUM_PHASES = 4;
  localparam int unsigned CODE_W     = $clog2(NUM_PHASES);
  localparam int unsigned LAMP_W     = 3;

  // phase indices, ring order is behaviour: A green -> A yellow -> B green -> B yellow
  localparam int unsigned PH_A_GRN = 0;
  localparam int unsigned PH_A_YEL = 1;
  localparam int unsigned PH_B_GRN = 2;
  localparam int unsigned PH_B_YEL = 3;

  localparam logic [LAMP_W-1:0] LAMP_RED = 3'b001;
  localparam logic [LAMP_W-1:0] LAMP_YEL = 3'b010;
  localparam logic [LAMP_W-1:0] LAMP_GRN = 3'b100;
endpackage

// File: rtl/tlc_state_onehot.sv
module tlc_state_onehot
  import tlc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  timing_in,
  output logic [NUM_PHASES-1:0] phase_vec
);
  logic [NUM_PHASES-1:0] state_q, state_d;
  logic                  upd_en;

  always_comb begin
    state_d = '0;
    state_d[PH_A_GRN] = (state_q[PH_A_GRN] & ~timing_in) | (state_q[PH_B_YEL] & ~timing_in);
    state_d[PH_A_YEL] = (state_q[PH_A_GRN] &  timing_in) | (state_q[PH_A_YEL] &  timing_in);
    state_d[PH_B_GRN] = (state_q[PH_A_YEL] & ~timing_in) | (state_q[PH_B_GRN] & ~timing_in);
    state_d[PH_B_YEL] = (state_q[PH_B_GRN] &  timing_in) | (state_q[PH_B_YEL] &  timing_in);
    upd_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= NUM_PHASES'(1) << PH_A_GRN;
    end else if (upd_en) begin
      state_q <= state_d;
    end
  end

  assign phase_vec = state_q;

  // R10
  onehot_state_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot(state_q));
endmodule

// File: rtl/tlc_state_bin.sv
module tlc_state_bin
  import tlc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  timing_in,
  output logic [NUM_PHASES-1:0] phase_vec
);
  logic [CODE_W-1:0] code_q, code_d;
  logic              adv_en;

  // code bit 0 is set in yellow phases; the phase advances whenever the level differs from it
  always_comb begin
    adv_en = timing_in ^ code_q[0];
    code_d = code_q + CODE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_W'(PH_A_GRN);
    end else if (adv_en) begin
      code_q <= code_d;
    end
  end

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_dec
    assign phase_vec[g] = (code_q == CODE_W'(g));
  end
endmodule

// File: rtl/tlc_lamp_dec.sv
module tlc_lamp_dec
  import tlc_pkg::*;
(
  input  logic [NUM_PHASES-1:0] phase_vec,
  output logic [LAMP_W-1:0]     lamp_a,
  output logic [LAMP_W-1:0]     lamp_b
);
  always_comb begin
    lamp_a = (phase_vec[PH_A_GRN] ? LAMP_GRN : '0)
           | (phase_vec[PH_A_YEL] ? LAMP_YEL : '0)
           | ((phase_vec[PH_B_GRN] | phase_vec[PH_B_YEL]) ? LAMP_RED : '0);
    lamp_b = (phase_vec[PH_B_GRN] ? LAMP_GRN : '0)
           | (phase_vec[PH_B_YEL] ? LAMP_YEL : '0)
           | ((phase_vec[PH_A_GRN] | phase_vec[PH_A_YEL]) ? LAMP_RED : '0);
  end
endmodule

// File: rtl/tlc_ctrl.sv
module tlc_ctrl
  import tlc_pkg::*;
#(
  parameter bit ENC_BINARY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              timing_in,
  output logic [LAMP_W-1:0] lamp_a,
  output logic [LAMP_W-1:0] lamp_b
);
  logic [NUM_PHASES-1:0] phase_vec;

  if (ENC_BINARY) begin : g_bin
    tlc_state_bin u_state (
      .clk(clk), .rst_n(rst_n), .timing_in(timing_in), .phase_vec(phase_vec)
    );
  end else begin : g_onehot
    tlc_state_onehot u_state (
      .clk(clk), .rst_n(rst_n), .timing_in(timing_in), .phase_vec(phase_vec)
    );
  end

  tlc_lamp_dec u_dec (
    .phase_vec(phase_vec), .lamp_a(lamp_a), .lamp_b(lamp_b)
  );

  // R8
  lamp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(lamp_a) && $onehot(lamp_b));
  // R9
  no_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_a[0] || lamp_b[0]);
  // R2
  green_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lamp_a == LAMP_GRN || lamp_b == LAMP_GRN) && !timing_in) |=> $stable(lamp_a) && $stable(lamp_b));
  // R4
  yellow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lamp_a == LAMP_YEL || lamp_b == LAMP_YEL) && timing_in) |=> $stable(lamp_a) && $stable(lamp_b));
  // R3
  a_to_yel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_a == LAMP_GRN && timing_in) |=> (lamp_a == LAMP_YEL && lamp_b == LAMP_RED));
  // R5
  b_to_grn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_a == LAMP_YEL && !timing_in) |=> (lamp_a == LAMP_RED && lamp_b == LAMP_GRN));
  // R6
  b_to_yel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_b == LAMP_GRN && timing_in) |=> (lamp_a == LAMP_RED && lamp_b == LAMP_YEL));
  // R7
  a_to_grn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_b == LAMP_YEL && !timing_in) |=> (lamp_a == LAMP_GRN && lamp_b == LAMP_RED));
endmodule

// File: tb/tlc_ctrl_bench.sv
`timescale 1ns/1ps
module tlc_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       timing_in = 1'b0;
  logic [2:0] la_oh, lb_oh, la_bn, lb_bn;
  int         n_chk = 0;
  int         n_fail = 0;
  int         ep = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  tlc_ctrl #(.ENC_BINARY(1'b0)) u_tlc_ctrl (
    .clk(clk), .rst_n(rst_n), .timing_in(timing_in), .lamp_a(la_oh), .lamp_b(lb_oh));
  tlc_ctrl #(.ENC_BINARY(1'b1)) u_tlc_ctrl_bin (
    .clk(clk), .rst_n(rst_n), .timing_in(timing_in), .lamp_a(la_bn), .lamp_b(lb_bn));

  function automatic logic [2:0] exp_a(int p);
    case (p)
      0: return 3'b100;
      1: return 3'b010;
      default: return 3'b001;
    endcase
  endfunction
  function automatic logic [2:0] exp_b(int p);
    case (p)
      2: return 3'b100;
      3: return 3'b010;
      default: return 3'b001;
    endcase
  endfunction

  task automatic check(string req);
    n_chk++;
    if (la_oh !== exp_a(ep) || lb_oh !== exp_b(ep)) begin
      n_fail++;
      $display("FAIL %s onehot: A=%b B=%b expected A=%b B=%b", req, la_oh, lb_oh, exp_a(ep), exp_b(ep));
    end
    n_chk++;
    if (la_bn !== exp_a(ep) || lb_bn !== exp_b(ep)) begin
      n_fail++;
      $display("FAIL %s R10 binary: A=%b B=%b expected A=%b B=%b", req, la_bn, lb_bn, exp_a(ep), exp_b(ep));
    end
    n_chk++;
    if (!(la_oh[0] || lb_oh[0]) || !(la_bn[0] || lb_bn[0])) begin
      n_fail++;
      $display("FAIL R9 conflict: A=%b/%b B=%b/%b expected a red head", la_oh, la_bn, lb_oh, lb_bn);
    end
  endtask

  // drive at negedge, one rising edge, sample at the following negedge
  task automatic step(bit t, string req);
    timing_in = t;
    @(posedge clk);
    if ((ep == 0 || ep == 2) && t) ep = ep + 1;
    else if ((ep == 1 || ep == 3) && !t) ep = (ep + 1) % 4;
    @(negedge clk);
    check(req);
  endtask

  task automatic test_reset();
    ep = 0;
    @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");
  endtask

  task automatic test_full_cycle();
    step(1'b0, "R2 A green hold");
    step(1'b0, "R2 A green hold");
    step(1'b1, "R3 A to yellow");
    step(1'b1, "R4 A yellow hold");
    step(1'b0, "R5 B to green");
    step(1'b0, "R2 B green hold");
    step(1'b1, "R6 B to yellow");
    step(1'b1, "R4 B yellow hold");
    step(1'b0, "R7 A to green");
  endtask

  task automatic test_short_pulses();
    for (int i = 0; i < 8; i++) step(i[0] ? 1'b0 : 1'b1, "R8 pulse ring");
  endtask

  task automatic test_long_holds();
    for (int i = 0; i < 20; i++) step(1'b0, "R2 long green");
    step(1'b1, "R3 leave green");
    for (int i = 0; i < 20; i++) step(1'b1, "R4 long yellow");
    step(1'b0, "R5 leave yellow");
  endtask

  task automatic test_mid_reset();
    step(1'b1, "R6 before reset");
    rst_n = 1'b0;
    #1;
    ep = 0;
    check("R1 async reset mid cycle");
    @(negedge clk);
    rst_n = 1'b1;
    timing_in = 1'b0;
    check("R1 released");
    step(1'b1, "R3 after reset");
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_full_cycle();
    test_short_pulses();
    test_long_holds();
    test_mid_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule